// File: doc/BRIEF.md
# Ring-Window Memory Writer

This block drives the memory-side write requests of a channel that moves 16-byte quadwords out of a local scratchpad into main memory. Each accepted burst produces one write request. The request carries the current memory address, the scratchpad source address and the quadword count. The request is held until memory acknowledges it, and then both addresses advance.

When the drain select names one of the two drain consumers, every destination address is folded into a power-of-two ring window. The window is described by a base and a mask. A burst that starts outside the window raises an error pulse. Only bursts that start inside the window add their quadwords to a deposit counter.

At the end of a channel step, a nonzero count is handed to the selected consumer through a one-cycle notify pulse, and the counter is cleared. In the no-drain and reserved settings, the address simply advances linearly.

Top module: `ring_dma_writer`

## Requirements
- R1: After reset, burst_ready_o is 1 and mem_req_o, win_err_o, notify_a_o and notify_b_o are 0.
- R2: A burst accepted with a nonzero count raises mem_req_o in the next cycle. The request carries the current memory address, source address and count, and holds them stable until mem_ack_i is seen.
- R3: With drain_sel_i equal to 00 (no drain) or 01 (reserved), the memory address after an acknowledged burst is the old address plus 16 times the count, with no wrapping.
- R4: With drain_sel_i equal to 10 (drain A) or 11 (drain B), the memory address after an acknowledged burst is ring_base_i plus ((old address + 16 × count) AND ring_mask_i).
- R5: In a ring setting, a burst whose start address with the mask bits cleared differs from ring_base_i gives a one-cycle win_err_o pulse in the cycle after acceptance. In a linear setting this pulse never occurs.
- R6: Only bursts in a ring setting that start inside the window add their count to the deposit counter.
- R7: The idle block can take step_end_i while the deposit count is nonzero and drain_sel_i is 10 or 11. In that case, in the next cycle it pulses notify_a_o (for 10) or notify_b_o (for 11) for one cycle, with the count on notify_qwc_o. It also clears the count and refolds the memory address to ring_base_i plus (address AND mask).
- R8: A step end with a zero deposit count produces no notify pulse.
- R9: The source address advances by 16 times the count after every acknowledged burst, whatever the drain setting.
- R10: A burst with a zero count is ignored: it produces no request and no error, and it does not change the addresses.
- R11: While step_end_i is high, burst_ready_o is low, so a step end takes priority over a burst.
- R12: A load_i pulse while idle, with no burst or step end in the same cycle, sets the memory and source addresses and leaves the deposit count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| drain_sel_i | input | 2 | Drain setting: 00 none, 01 reserved, 10 drain A, 11 drain B |
| ring_base_i | input | AW | Ring window base, aligned to ring size |
| ring_mask_i | input | AW | Ring size in bytes minus 1 |
| load_i | input | 1 | Load address registers |
| load_maddr_i | input | AW | Memory address to load |
| load_saddr_i | input | AW | Scratchpad address to load |
| burst_valid_i | input | 1 | Burst request |
| burst_qwc_i | input | QW | Burst quadword count |
| burst_ready_o | output | 1 | Burst can be accepted |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Destination byte address |
| mem_saddr_o | output | AW | Scratchpad source byte address |
| mem_qwc_o | output | QW | Quadwords in this write |
| mem_ack_i | input | 1 | Memory completion |
| step_end_i | input | 1 | Channel step finished |
| win_err_o | output | 1 | Burst started outside the ring window |
| notify_a_o | output | 1 | Count handed to drain A |
| notify_b_o | output | 1 | Count handed to drain B |
| notify_qwc_o | output | CW | Quadword count carried by notify |

## Verification
In drain A, the bursts run up to the ring's upper edge and then cross it. This separates a correct fold from plain linear advance, and the notify total shows whether every inside burst was counted. A burst loaded far outside the window tells the error flag and the counter exclusion apart from the normal wrap. The same addresses in the no-drain and reserved settings show that neither folding nor flagging happens there. A count left pending while the address is moved outside the window proves that the step end refolds the address and routes the pulse to drain B. Zero-count bursts, back-to-back step ends and a step end held against a ready check cover the remaining corners.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_RSVD  = 2'b01,
    SEL_DRN_A = 2'b10,
    SEL_DRN_B = 2'b11
  } drain_sel_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } wr_state_e;

  localparam int unsigned QW_BYTES_LOG2 = 4;
endpackage

// File: rtl/ring_fold.sv
module ring_fold #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] add_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic          ring_en_i,
  output logic [AW-1:0] next_o,
  output logic          outside_o
);
  logic [AW-1:0] sum;

  always_comb begin
    sum       = addr_i + add_i;
    next_o    = ring_en_i ? (base_i + (sum & mask_i)) : sum;
    outside_o = ring_en_i && ((addr_i & ~mask_i) != base_i);
  end
endmodule

// File: rtl/deposit_ctr.sv
module deposit_ctr #(
  parameter int unsigned QW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_i,
  input  logic [QW-1:0] val_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (add_i) cnt_o <= cnt_o + CW'(val_i);
  end
endmodule

// File: rtl/ring_dma_writer.sv
module ring_dma_writer
  import ring_dma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned QW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    drain_sel_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [AW-1:0] ring_mask_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_maddr_i,
  input  logic [AW-1:0] load_saddr_i,
  input  logic          burst_valid_i,
  input  logic [QW-1:0] burst_qwc_i,
  output logic          burst_ready_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_saddr_o,
  output logic [QW-1:0] mem_qwc_o,
  input  logic          mem_ack_i,
  input  logic          step_end_i,
  output logic          win_err_o,
  output logic          notify_a_o,
  output logic          notify_b_o,
  output logic [CW-1:0] notify_qwc_o
);
  localparam int unsigned SH = QW_BYTES_LOG2;

  wr_state_e     st_q;
  logic [AW-1:0] maddr_q, saddr_q;
  logic [QW-1:0] qwc_q;
  logic          ring_q, inside_q;
  logic [CW-1:0] cnt;

  logic          ring_en, idle, accept, step_go, flush, done;
  logic [AW-1:0] burst_bytes, burst_next, fold_now;
  logic          burst_out_unused, out_now;

  assign ring_en       = drain_sel_i[1];
  assign idle          = (st_q == ST_IDLE);
  assign burst_ready_o = idle && !step_end_i;
  assign accept        = burst_ready_o && burst_valid_i && (burst_qwc_i != '0);
  assign step_go       = idle && step_end_i;
  assign flush         = step_go && ring_en && (cnt != '0);
  assign done          = (st_q == ST_WRITE) && mem_ack_i;
  assign burst_bytes   = AW'(qwc_q) << SH;

  // fold applied after a completed burst
  ring_fold #(.AW(AW)) u_fold_burst (
    .addr_i   (maddr_q),
    .add_i    (burst_bytes),
    .base_i   (ring_base_i),
    .mask_i   (ring_mask_i),
    .ring_en_i(ring_q),
    .next_o   (burst_next),
    .outside_o(burst_out_unused)
  );

  // window check at accept, refold at step end
  ring_fold #(.AW(AW)) u_fold_now (
    .addr_i   (maddr_q),
    .add_i    ('0),
    .base_i   (ring_base_i),
    .mask_i   (ring_mask_i),
    .ring_en_i(ring_en),
    .next_o   (fold_now),
    .outside_o(out_now)
  );

  deposit_ctr #(.QW(QW), .CW(CW)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .add_i (done && ring_q && inside_q),
    .val_i (qwc_q),
    .clr_i (flush),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      qwc_q    <= '0;
      ring_q   <= 1'b0;
      inside_q <= 1'b0;
    end else if (accept) begin
      st_q     <= ST_WRITE;
      qwc_q    <= burst_qwc_i;
      ring_q   <= ring_en;
      inside_q <= !out_now;
    end else if (done) begin
      st_q     <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maddr_q <= '0;
      saddr_q <= '0;
    end else if (done) begin
      maddr_q <= burst_next;
      saddr_q <= saddr_q + burst_bytes;
    end else if (flush) begin
      maddr_q <= fold_now;
    end else if (load_i && burst_ready_o && !burst_valid_i) begin
      maddr_q <= load_maddr_i;
      saddr_q <= load_saddr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_err_o    <= 1'b0;
      notify_a_o   <= 1'b0;
      notify_b_o   <= 1'b0;
      notify_qwc_o <= '0;
    end else begin
      win_err_o    <= accept && out_now;
      notify_a_o   <= flush && (drain_sel_i == SEL_DRN_A);
      notify_b_o   <= flush && (drain_sel_i == SEL_DRN_B);
      notify_qwc_o <= flush ? cnt : '0;
    end
  end

  assign mem_req_o   = (st_q == ST_WRITE);
  assign mem_addr_o  = maddr_q;
  assign mem_saddr_o = saddr_q;
  assign mem_qwc_o   = qwc_q;
endmodule

// File: rtl/ring_dma_writer_chk.sv
module ring_dma_writer_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned QW = 16,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          burst_valid_i,
  input logic          burst_ready_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] mem_saddr_o,
  input logic [QW-1:0] mem_qwc_o,
  input logic          mem_ack_i,
  input logic          step_end_i,
  input logic          win_err_o,
  input logic          notify_a_o,
  input logic          notify_b_o,
  input logic [CW-1:0] notify_qwc_o
);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_saddr_o) && $stable(mem_qwc_o)));
  // R5
  err_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_err_o |-> $past(burst_valid_i && burst_ready_o));
  // R7
  notify_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({notify_a_o, notify_b_o}));
  // R8
  notify_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_a_o || notify_b_o) |-> (notify_qwc_o != '0));
  // R11
  step_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_end_i |-> !burst_ready_o);
  // R2
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(burst_ready_o && mem_req_o));
endmodule

bind ring_dma_writer ring_dma_writer_chk #(.AW(AW), .QW(QW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .burst_valid_i(burst_valid_i),
  .burst_ready_o(burst_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_saddr_o  (mem_saddr_o),
  .mem_qwc_o    (mem_qwc_o),
  .mem_ack_i    (mem_ack_i),
  .step_end_i   (step_end_i),
  .win_err_o    (win_err_o),
  .notify_a_o   (notify_a_o),
  .notify_b_o   (notify_b_o),
  .notify_qwc_o (notify_qwc_o)
);

// File: tb/ring_dma_writer_tb.sv
module ring_dma_writer_tb;
  localparam int AW = 32;
  localparam int QW = 16;
  localparam int CW = 16;
  localparam logic [AW-1:0] BASE = 32'h0000_2000;
  localparam logic [AW-1:0] MASK = 32'h0000_0FFF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] drain_sel = 2'b10;
  logic load = 0, burst_valid = 0, mem_ack = 0, step_end = 0;
  logic [AW-1:0] load_maddr = '0, load_saddr = '0;
  logic [QW-1:0] burst_qwc = '0;
  logic burst_ready, mem_req, win_err, notify_a, notify_b;
  logic [AW-1:0] mem_addr, mem_saddr;
  logic [QW-1:0] mem_qwc;
  logic [CW-1:0] notify_qwc;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_maddr, m_saddr;
  int m_cnt = 0;
  logic [2*AW+QW-1:0] exp_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  ring_dma_writer #(.AW(AW), .QW(QW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .drain_sel_i(drain_sel),
    .ring_base_i(BASE), .ring_mask_i(MASK),
    .load_i(load), .load_maddr_i(load_maddr), .load_saddr_i(load_saddr),
    .burst_valid_i(burst_valid), .burst_qwc_i(burst_qwc), .burst_ready_o(burst_ready),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_saddr_o(mem_saddr),
    .mem_qwc_o(mem_qwc), .mem_ack_i(mem_ack), .step_end_i(step_end),
    .win_err_o(win_err), .notify_a_o(notify_a), .notify_b_o(notify_b),
    .notify_qwc_o(notify_qwc)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected write request", 64'(mem_addr), 0);
        end else begin
          logic [2*AW+QW-1:0] e;
          e = exp_q.pop_front();
          check({mem_addr, mem_saddr, mem_qwc} == e, "R2 R3 R4 R9 write request",
                64'({mem_addr, mem_qwc}), 64'({e[2*AW+QW-1 -: AW], e[QW-1:0]}));
        end
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic load_addr(input logic [AW-1:0] ma, input logic [AW-1:0] sa);
    @(negedge clk);
    load = 1; load_maddr = ma; load_saddr = sa;
    @(negedge clk);
    load = 0;
    m_maddr = ma; m_saddr = sa; // R12: count kept
  endtask

  task automatic burst(input int q);
    bit ring, outside;
    logic [AW-1:0] nxt;
    @(negedge clk);
    ring    = drain_sel[1];
    outside = ring && ((m_maddr & ~MASK) != BASE);
    nxt     = m_maddr + AW'(q * 16);
    if (ring) nxt = BASE + (nxt & MASK);
    if (q != 0) exp_q.push_back({m_maddr, m_saddr, QW'(q)});
    burst_valid = 1; burst_qwc = QW'(q);
    @(negedge clk);
    burst_valid = 0;
    check(win_err == (q != 0 && outside), "R5 window error pulse", 64'(win_err),
          64'(q != 0 && outside));
    if (q == 0) begin
      check(!mem_req && burst_ready, "R10 zero burst ignored", 64'(mem_req), 0);
    end else begin
      m_maddr = nxt;
      m_saddr = m_saddr + AW'(q * 16);
      if (ring && !outside) m_cnt += q; // R6
    end
    while (!burst_ready) @(negedge clk);
  endtask

  task automatic step();
    bit flush;
    flush = (m_cnt != 0) && drain_sel[1];
    @(negedge clk);
    step_end = 1;
    #1;
    check(!burst_ready, "R11 step end blocks bursts", 64'(burst_ready), 0);
    @(negedge clk);
    step_end = 0;
    check(notify_a == (flush && drain_sel == 2'b10), "R7 R8 notify_a", 64'(notify_a),
          64'(flush && drain_sel == 2'b10));
    check(notify_b == (flush && drain_sel == 2'b11), "R7 R8 notify_b", 64'(notify_b),
          64'(flush && drain_sel == 2'b11));
    check(notify_qwc == (flush ? CW'(m_cnt) : '0), "R7 notify count", 64'(notify_qwc),
          64'(flush ? m_cnt : 0));
    @(negedge clk);
    check(!notify_a && !notify_b, "R7 notify single cycle", 64'({notify_a, notify_b}), 0);
    if (flush) begin
      m_maddr = BASE + (m_maddr & MASK);
      m_cnt = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(burst_ready && !mem_req && !win_err && !notify_a && !notify_b,
          "R1 reset state", 64'({burst_ready, mem_req, win_err, notify_a, notify_b}),
          64'b10000);
    rst_ni = 1;
    // drain A: approach and cross ring top
    drain_sel = 2'b10;
    load_addr(32'h2F00, 32'h100);
    burst(8); burst(16); burst(2);
    step();          // R7: 26 quadwords
    step();          // R8: nothing pending
    // outside start: flagged and not counted
    load_addr(32'h5000, 32'h400);
    burst(4); burst(4);
    step();          // R6: only 4 counted
    // linear settings
    drain_sel = 2'b00;
    load_addr(32'h2FF0, 32'h800);
    burst(4); burst(4);
    drain_sel = 2'b01;
    burst(1);
    step();
    // drain B with address moved away before step end
    drain_sel = 2'b11;
    load_addr(32'h2FE0, 32'h40);
    burst(3);
    load_addr(32'h7010, 32'h900); // R12: count survives
    step();          // R7: refold to 0x2010, notify_b 3
    burst(1);
    burst(0);        // R10
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all requests issued", 64'(exp_q.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule